// File: doc/BRIEF.md
# Big-Endian Load/Store Unit

This block sits between an execute stage and a data memory port that is one 32-bit word wide. Each cycle the execute stage may present one access: an opcode, a base register value, a signed 16-bit displacement and, for stores, the register value to write. The unit adds the displacement to the base to form a byte address. It then either drives a store with a byte-lane mask, or issues a read and returns the aligned, extended result one cycle later.

Bytes are numbered big-endian inside a word. The byte at offset 0 sits in bits 31:24 and the byte at offset 3 sits in bits 7:0. The port always sees a word address. A word access whose byte address is not a multiple of four raises a fault in the same cycle, and no memory request is made for it. Byte accesses can never fault. Opcodes the unit does not recognise produce neither a request nor a fault.

Top module: `ldst_unit`

## Requirements
- R1: The byte address is the base plus the 16-bit displacement, sign-extended. `mem_addr` equals that address with bits 1:0 forced to zero whenever a read or write is issued.
- R2: Opcode 0x23 is a word load, 0x2B a word store, 0x20 a byte load and 0x28 a byte store. Any other opcode, or `req_valid` low, issues no read, no write and no fault.
- R3: A word load or word store whose byte address has bits 1:0 not both zero raises `fault` in the same cycle and issues neither `mem_rd` nor `mem_wr`, so memory is left unchanged.
- R4: A word store drives `mem_wdata` equal to the register value and `mem_be` equal to 4'b1111.
- R5: A byte store copies register bits 7:0 into all four lanes and sets exactly one `mem_be` bit. Address offset 0 selects `mem_be[3]` (bits 31:24) and offset 3 selects `mem_be[0]` (bits 7:0).
- R6: A load drives `mem_rd` in its request cycle. `ld_valid` is high in the following cycle only, and `ld_data` is valid in that same cycle.
- R7: A word load returns `mem_rdata` unchanged on `ld_data`.
- R8: A byte load picks the big-endian lane named by address bits 1:0 (offset 0 from bits 31:24) and sign-extends it to 32 bits.
- R9: While `rst_n` is low, and in the first cycle after reset, `ld_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_op | input | 6 | Access opcode |
| req_base | input | 32 | Base register value |
| req_ofs | input | 16 | Signed byte displacement |
| req_wval | input | 32 | Register value to store |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 32 | Write word |
| mem_be | output | 4 | Byte-lane write enables, bit 3 = bits 31:24 |
| mem_rdata | input | 32 | Read word, valid the cycle after `mem_rd` |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Aligned load result |
| fault | output | 1 | Misaligned word access this cycle |

## Verification
The embedded properties check, on every cycle, that a fault never comes with a memory request and that issued addresses are word-aligned. They also check that a byte store enables exactly one lane while a word store enables all four, and that `ld_valid` follows a read by exactly one cycle. Whether the correct lane is chosen, whether the sign extension is right and whether the sum with a negative displacement is correct can only be seen through the bench's scenarios. These compare every port against a behavioural model of the access and of a small memory. Examples are byte stores assembling a word that a later word load reads back, and a faulting store followed by a load showing that memory did not change.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam logic [5:0] OPC_LOAD_WORD  = 6'h23;
  localparam logic [5:0] OPC_STORE_WORD = 6'h2B;
  localparam logic [5:0] OPC_LOAD_BYTE  = 6'h20;
  localparam logic [5:0] OPC_STORE_BYTE = 6'h28;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_LDW,
    ACC_STW,
    ACC_LDB,
    ACC_STB
  } acc_kind_e;
endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
(
  input  logic       valid,
  input  logic [5:0] op,
  output acc_kind_e  kind,
  output logic       is_load,
  output logic       is_store,
  output logic       is_byte
);
  always_comb begin
    kind = ACC_NONE;
    if (valid) begin
      unique case (op)
        OPC_LOAD_WORD:  kind = ACC_LDW;
        OPC_STORE_WORD: kind = ACC_STW;
        OPC_LOAD_BYTE:  kind = ACC_LDB;
        OPC_STORE_BYTE: kind = ACC_STB;
        default:        kind = ACC_NONE;
      endcase
    end
  end

  assign is_load  = (kind == ACC_LDW) || (kind == ACC_LDB);
  assign is_store = (kind == ACC_STW) || (kind == ACC_STB);
  assign is_byte  = (kind == ACC_LDB) || (kind == ACC_STB);
endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned LANE_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              word_acc,
  output logic [ADDR_W-1:0] word_addr,
  output logic [LANE_W-1:0] lane,
  output logic              misalign
);
  localparam int unsigned EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ofs_ext;
  logic [ADDR_W-1:0] byte_addr;

  assign ofs_ext   = {{EXT_W{ofs[OFS_W-1]}}, ofs};
  assign byte_addr = base + ofs_ext;
  assign lane      = byte_addr[LANE_W-1:0];
  assign word_addr = {byte_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign misalign  = word_acc && (lane != '0);
endmodule

// File: rtl/ldst_store_fmt.sv
module ldst_store_fmt #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = DATA_W / 8,
  parameter int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] wval,
  input  logic              is_byte,
  input  logic [LANE_W-1:0] lane,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // physical lane g holds big-endian byte offset LANES-1-g
    localparam logic [LANE_W-1:0] OFFS = LANE_W'(LANES - 1 - g);
    assign wdata[8*g +: 8] = is_byte ? wval[7:0] : wval[8*g +: 8];
    assign be[g]           = is_byte ? (lane == OFFS) : 1'b1;
  end
endmodule

// File: rtl/ldst_load_align.sv
module ldst_load_align #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = DATA_W / 8,
  parameter int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              issue_byte,
  input  logic [LANE_W-1:0] issue_lane,
  input  logic [DATA_W-1:0] rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  logic              pend_q, pend_d;
  logic              byte_q, byte_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic              ctx_en;
  logic [7:0]        by_offs [LANES];
  logic [7:0]        picked;

  assign ctx_en = issue;

  always_comb begin
    pend_d = issue;
    byte_d = byte_q;
    lane_d = lane_q;
    if (ctx_en) begin
      byte_d = issue_byte;
      lane_d = issue_lane;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      byte_q <= 1'b0;
      lane_q <= '0;
    end else begin
      pend_q <= pend_d;
      byte_q <= byte_d;
      lane_q <= lane_d;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    assign by_offs[k] = rdata[DATA_W-1-8*k -: 8];
  end

  assign picked   = by_offs[lane_q];
  assign ld_valid = pend_q;
  assign ld_data  = byte_q ? {{(DATA_W-8){picked[7]}}, picked} : rdata;

  // R6: a result appears exactly one cycle after each issued read
  assert_result_follows_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> ld_valid);
  assert_no_result_without_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !ld_valid);
  // R8: a byte result is a sign extension of its low byte
  assert_byte_sign_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && byte_q) |-> (ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}}));
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [5:0]        req_op,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [DATA_W-1:0] req_wval,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W/8-1:0] mem_be,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic              fault
);
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);

  acc_kind_e         kind;
  logic              is_load, is_store, is_byte;
  logic              misalign;
  logic [LANE_W-1:0] lane;

  ldst_decode u_decode (
    .valid    (req_valid),
    .op       (req_op),
    .kind     (kind),
    .is_load  (is_load),
    .is_store (is_store),
    .is_byte  (is_byte)
  );

  ldst_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .LANE_W(LANE_W)) u_addr (
    .base      (req_base),
    .ofs       (req_ofs),
    .word_acc  ((is_load || is_store) && !is_byte),
    .word_addr (mem_addr),
    .lane      (lane),
    .misalign  (misalign)
  );

  ldst_store_fmt #(.DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .wval    (req_wval),
    .is_byte (is_byte),
    .lane    (lane),
    .wdata   (mem_wdata),
    .be      (mem_be)
  );

  assign mem_rd = is_load  && !misalign;
  assign mem_wr = is_store && !misalign;
  assign fault  = misalign;

  ldst_load_align #(.DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)) u_load (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (mem_rd),
    .issue_byte (is_byte),
    .issue_lane (lane),
    .rdata      (mem_rdata),
    .ld_valid   (ld_valid),
    .ld_data    (ld_data)
  );

  // R3: a faulting access never reaches memory
  assert_fault_blocks_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!mem_rd && !mem_wr));
  // R1: issued addresses are word aligned
  assert_word_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (mem_addr[LANE_W-1:0] == '0));
  // R2: never both a read and a write
  assert_single_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R5: a byte store enables exactly one lane
  assert_byte_store_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && kind == ACC_STB) |-> ($countones(mem_be) == 1));
  // R4: a word store enables every lane
  assert_word_store_all_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && kind == ACC_STW) |-> (&mem_be));
endmodule

// File: tb/ldst_unit_bench.sv
module ldst_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [5:0]  req_op;
  logic [31:0] req_base;
  logic [15:0] req_ofs;
  logic [31:0] req_wval;
  logic [31:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata;
  logic        ld_valid;
  logic [31:0] ld_data;
  logic        fault;

  int checks = 0;
  int fails  = 0;

  logic [31:0] mem [16];
  logic        exp_v;
  logic [31:0] exp_d;

  always #5 clk = ~clk;

  ldst_unit u_ldst_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_ofs(req_ofs), .req_wval(req_wval),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .fault(fault)
  );

  // behavioural memory: writes land at the edge, reads answer one cycle later
  always @(posedge clk) begin
    if (mem_wr)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    mem_rdata <= mem_rd ? mem[mem_addr[5:2]] : 32'h0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [5:0] op, input logic [31:0] base,
                      input logic [15:0] ofs, input logic [31:0] wv, input string req);
    int          ea;
    int          off;
    bit          rd, wr, flt, byt, known;
    logic [31:0] w, ew;
    logic [3:0]  eb;
    logic [7:0]  sb;
    @(negedge clk);
    req_valid = v; req_op = op; req_base = base; req_ofs = ofs; req_wval = wv;
    #1;
    ea    = int'(base) + int'($signed(ofs));
    off   = ea & 3;
    known = v && (op == 6'h23 || op == 6'h2B || op == 6'h20 || op == 6'h28);
    byt   = (op == 6'h20 || op == 6'h28);
    flt   = known && !byt && off != 0;
    rd    = known && !flt && (op == 6'h23 || op == 6'h20);
    wr    = known && !flt && (op == 6'h2B || op == 6'h28);
    chk(mem_rd == rd, {req, " mem_rd"}, {31'h0, mem_rd}, {31'h0, rd});
    chk(mem_wr == wr, {req, " mem_wr"}, {31'h0, mem_wr}, {31'h0, wr});
    chk(fault == flt, {req, " fault"}, {31'h0, fault}, {31'h0, flt});
    if (rd || wr)
      chk(mem_addr == (32'(ea) & ~32'h3), "R1 mem_addr", mem_addr, 32'(ea) & ~32'h3);
    if (wr) begin
      if (byt) begin
        ew = {4{wv[7:0]}};
        eb = 4'b1000 >> off;
      end else begin
        ew = wv;
        eb = 4'hF;
      end
      chk(mem_wdata == ew, {req, " wdata"}, mem_wdata, ew);
      chk(mem_be == eb, {req, " be"}, {28'h0, mem_be}, {28'h0, eb});
    end
    chk(ld_valid == exp_v, "R6 ld_valid", {31'h0, ld_valid}, {31'h0, exp_v});
    if (exp_v) chk(ld_data == exp_d, "R7/R8 ld_data", ld_data, exp_d);
    exp_v = rd;
    if (rd) begin
      w = mem[(ea >> 2) & 15];
      if (byt) begin
        sb    = w[31 - 8*off -: 8];
        exp_d = 32'($signed(sb));
      end else begin
        exp_d = w;
      end
    end
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    exp_v = 1'b0; exp_d = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_base = '0; req_ofs = '0; req_wval = '0;
    repeat (3) @(negedge clk);
    chk(ld_valid == 1'b0, "R9 ld_valid in reset", {31'h0, ld_valid}, 32'h0);
    rst_n = 1'b1;
    step(1'b0, 6'h00, 32'h0, 16'h0, 32'h0, "R9 idle after reset");
    // R4: word store, R7: word load back
    step(1'b1, 6'h2B, 32'h0000_0000, 16'h0004, 32'hCAFE_F00D, "R4 sw");
    step(1'b1, 6'h23, 32'h0000_0008, 16'hFFFC, 32'h0, "R1 lw negative offset");
    // R5: byte stores assembling a word at address 8
    step(1'b1, 6'h28, 32'h0000_0008, 16'h0000, 32'h1234_56A1, "R5 sb off0");
    step(1'b1, 6'h28, 32'h0000_0008, 16'h0001, 32'h0000_00B2, "R5 sb off1");
    step(1'b1, 6'h28, 32'h0000_000A, 16'h0000, 32'hFFFF_FF43, "R5 sb off2");
    step(1'b1, 6'h28, 32'h0000_0010, 16'hFFFB, 32'h0000_0054, "R5 sb off3");
    step(1'b1, 6'h23, 32'h0000_0008, 16'h0000, 32'h0, "R7 lw assembled");
    // R8: byte loads of every lane, negative and positive
    step(1'b1, 6'h20, 32'h0000_0008, 16'h0000, 32'h0, "R8 lb off0");
    step(1'b1, 6'h20, 32'h0000_0008, 16'h0001, 32'h0, "R8 lb off1");
    step(1'b1, 6'h20, 32'h0000_0008, 16'h0002, 32'h0, "R8 lb off2");
    step(1'b1, 6'h20, 32'h0000_0008, 16'h0003, 32'h0, "R8 lb off3");
    step(1'b1, 6'h20, 32'h0000_0004, 16'h0000, 32'h0, "R8 lb neg off0");
    // R3: misaligned word accesses
    step(1'b1, 6'h2B, 32'h0000_0004, 16'h0002, 32'hDEAD_BEEF, "R3 sw misaligned");
    step(1'b1, 6'h23, 32'h0000_0004, 16'h0001, 32'h0, "R3 lw misaligned");
    step(1'b1, 6'h23, 32'h0000_0004, 16'h0000, 32'h0, "R3 memory unchanged");
    // R2: unknown opcode and invalid request
    step(1'b1, 6'h29, 32'h0000_0004, 16'h0000, 32'h1111_1111, "R2 unknown op");
    step(1'b0, 6'h2B, 32'h0000_0004, 16'h0000, 32'h2222_2222, "R2 valid low");
    step(1'b1, 6'h23, 32'h0000_0004, 16'h0000, 32'h0, "R2 memory unchanged");
    // R6: back-to-back loads, then idle
    step(1'b1, 6'h20, 32'h0000_0005, 16'h0000, 32'h0, "R6 b2b 1");
    step(1'b1, 6'h23, 32'h0000_0008, 16'h0000, 32'h0, "R6 b2b 2");
    step(1'b0, 6'h00, 32'h0, 16'h0, 32'h0, "R6 idle");
    step(1'b0, 6'h00, 32'h0, 16'h0, 32'h0, "R6 idle");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule